// File: doc/BRIEF.md
# Buffered SPI Master with Status Flags

This block is a byte-wide SPI master (clock idle low, data launched on the falling edge, captured on the rising edge). It sits behind a small CPU-facing register window. Software writes a byte into a one-deep transmit holding buffer. The shifter takes that byte as soon as it is free. While the byte goes out most significant bit first, a byte is gathered from the slave line and placed in a one-deep receive holding buffer.

Three status flags describe the state of the block: a receive-ready flag, a frame-finished flag and a holding-buffer-free flag. Each flag sets and clears by its own rules. A control register holds three interrupt enables and separate receiver and transmitter enables. Each of the three interrupt request outputs is the AND of its enable, its flag and a global enable input. The serial clock half period is fixed by a parameter.

Register window (address, content): 0 = data (write fills the transmit buffer, read returns and consumes the receive buffer); 1 = status; 2 = control; 3 = reads zero.

Top module: `bspi_master`

## Requirements
- R1: After reset the status register reads 0x20 (only bit 5, buffer free, set), the control register reads 0x00, sck is low and all three interrupt requests are low.
- R2: With the transmitter enabled (control bit 3) and the shifter idle, a write to address 0 clears status bit 5 for exactly one cycle. On the next clock the byte moves into the shifter and bit 5 returns to 1.
- R3: A frame is 8 sck pulses, each half of the sck period lasting HALF_DIV clocks, with sck low when idle. mosi carries the byte most significant bit first and changes only while sck falls. miso is captured when sck rises.
- R4: When the eighth bit has been captured, the received byte enters the receive buffer and status bit 7 becomes 1. A read of address 0 returns that byte and clears bit 7.
- R5: Writing the control register with the receiver enable (bit 4) at 0 empties the receive buffer, forcing status bit 7 to 0. While the receiver is disabled, completed frames leave bit 7 at 0.
- R6: Status bit 6 sets at the end of a frame only if the transmit buffer is empty at that moment. With a second byte already buffered, the frames run back to back and bit 6 stays 0 until the last one ends.
- R7: Status bit 6 clears on a one-cycle pulse of txc_ack, or on a write to address 1 with bit 6 at 1. A write with bit 6 at 0 leaves it unchanged.
- R8: Status bits 4 to 0 always read 0. Writes to address 1 do not alter bits 7 and 5.
- R9: Control bits 7, 6 and 5 are the interrupt enables for status bits 7, 6 and 5, bit 4 enables the receiver and bit 3 the transmitter. Bits 2 to 0 read 0.
- R10: irq_rxc, irq_txc and irq_dre are each high exactly when gie is 1, the matching control enable is 1 and the matching status flag is 1.
- R11: A write to address 0 is dropped when the transmitter is disabled or the transmit buffer is already full. No frame is sent for it, and status bit 5 is left unchanged.
- R12: A byte received while status bit 7 is already set replaces the unread byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (consumes receive data at address 0) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| gie | input | 1 | Global interrupt enable |
| txc_ack | input | 1 | Acknowledge of the frame-finished interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |
| irq_rxc | output | 1 | Receive-ready interrupt request |
| irq_txc | output | 1 | Frame-finished interrupt request |
| irq_dre | output | 1 | Buffer-free interrupt request |

## Verification
A slave model returns a different byte pattern for every frame (0x3C, 0xC3, alternating and single-bit-heavy bytes). A bit-order or capture-edge error therefore shows up as a mismatched byte, not as a coincidental match. Single isolated frames are set against a pair queued back to back. This separates correct frame-finished gating and buffer handoff from a design that raises the flag after every frame or loses the buffered byte. A third byte written while the buffer is full, and one written with the transmitter off, must produce no frame. Frames with the receiver disabled and with an unread byte still pending tell flushing apart from overwriting.

// File: rtl/bspi_pkg.sv
package bspi_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        A_DATA = 2'd0,
        A_STAT = 2'd1,
        A_CTRL = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    // status bit positions
    localparam int unsigned STAT_RXC = 7;
    localparam int unsigned STAT_TXC = 6;
    localparam int unsigned STAT_DRE = 5;

    // control register occupies the upper bits, msb first
    typedef struct packed {
        logic rxc_ie;
        logic txc_ie;
        logic dre_ie;
        logic rx_en;
        logic tx_en;
    } ctrl_t;

    localparam int unsigned CTRL_W   = $bits(ctrl_t);
    localparam int unsigned CTRL_LSB = BYTE_W - CTRL_W;

endpackage

// File: rtl/bspi_shifter.sv
module bspi_shifter
    import bspi_pkg::*;
#(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  byte_t load_data,
    input  logic  miso,
    output logic  sck,
    output logic  mosi,
    output logic  busy,
    output logic  rx_push,
    output logic  frame_done,
    output byte_t rx_byte
);

    localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);
    localparam int unsigned BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

    typedef struct packed {
        logic             busy;
        logic             sck;
        logic             samp;
        logic [CNT_W-1:0] cnt;
        logic [BIT_W-1:0] bitn;
        byte_t            shreg;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        rx_push    = 1'b0;
        frame_done = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.cnt = '0;
                if (!st_q.sck) begin
                    // rising edge: capture the slave bit
                    st_d.sck  = 1'b1;
                    st_d.samp = miso;
                    rx_push   = (st_q.bitn == BIT_LAST);
                end else begin
                    // falling edge: advance to the next bit
                    st_d.sck   = 1'b0;
                    st_d.shreg = {st_q.shreg[BYTE_W-2:0], st_q.samp};
                    if (st_q.bitn == BIT_LAST) begin
                        st_d.busy  = 1'b0;
                        st_d.bitn  = '0;
                        frame_done = 1'b1;
                    end else begin
                        st_d.bitn = st_q.bitn + BIT_W'(1);
                    end
                end
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
        if (load) begin
            st_d.busy  = 1'b1;
            st_d.sck   = 1'b0;
            st_d.cnt   = '0;
            st_d.bitn  = '0;
            st_d.shreg = load_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sck     = st_q.sck;
    assign mosi    = st_q.shreg[BYTE_W-1];
    assign busy    = st_q.busy;
    assign rx_byte = {st_q.shreg[BYTE_W-2:0], miso};

endmodule

// File: rtl/bspi_bufs.sv
module bspi_bufs
    import bspi_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tx_en,
    input  logic  rx_en,
    input  logic  data_wr,
    input  byte_t wdata,
    input  logic  rx_pop,
    input  logic  rx_flush,
    input  logic  txc_w1c,
    input  logic  txc_ack,
    input  logic  busy,
    input  logic  frame_done,
    input  logic  rx_push,
    input  byte_t rx_byte,
    output logic  load,
    output byte_t load_data,
    output byte_t rx_data,
    output logic  rxc,
    output logic  txc,
    output logic  dre
);

    typedef struct packed {
        logic  tx_full;
        byte_t tx_byte;
        logic  rx_full;
        byte_t rx_hold;
        logic  txc;
    } buf_state_t;

    buf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // hand the buffered byte to the shifter when it is free or finishing
        load = st_q.tx_full && tx_en && (!busy || frame_done);
        if (load) st_d.tx_full = 1'b0;
        if (data_wr && tx_en && !st_q.tx_full) begin
            st_d.tx_full = 1'b1;
            st_d.tx_byte = wdata;
        end
        // receive side: pop, then a new byte, then a flush has the last word
        if (rx_pop) st_d.rx_full = 1'b0;
        if (rx_push && rx_en) begin
            st_d.rx_full = 1'b1;
            st_d.rx_hold = rx_byte;
        end
        if (rx_flush) st_d.rx_full = 1'b0;
        // frame-finished flag: setting beats clearing
        if (txc_w1c || txc_ack) st_d.txc = 1'b0;
        if (frame_done && !st_q.tx_full) st_d.txc = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_data = st_q.tx_byte;
    assign rx_data   = st_q.rx_hold;
    assign rxc       = st_q.rx_full;
    assign txc       = st_q.txc;
    assign dre       = !st_q.tx_full;

endmodule

// File: rtl/bspi_regs.sv
module bspi_regs
    import bspi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  byte_t      wdata,
    input  logic       gie,
    input  logic       rxc,
    input  logic       txc,
    input  logic       dre,
    input  byte_t      rx_data,
    output byte_t      rdata,
    output logic       tx_en,
    output logic       rx_en,
    output logic       data_wr,
    output logic       rx_pop,
    output logic       rx_flush,
    output logic       txc_w1c,
    output logic       irq_rxc,
    output logic       irq_txc,
    output logic       irq_dre
);

    ctrl_t ctrl_d, ctrl_q;
    ctrl_t wr_ctrl;
    byte_t status;
    logic  ctrl_wr;

    always_comb begin
        ctrl_d  = ctrl_q;
        wr_ctrl = ctrl_t'(wdata[BYTE_W-1:CTRL_LSB]);
        ctrl_wr = wr_en && (addr == A_CTRL);
        if (ctrl_wr) ctrl_d = wr_ctrl;

        data_wr  = wr_en && (addr == A_DATA);
        rx_pop   = rd_en && (addr == A_DATA);
        rx_flush = ctrl_wr && !wr_ctrl.rx_en;
        txc_w1c  = wr_en && (addr == A_STAT) && wdata[STAT_TXC];

        status           = '0;
        status[STAT_RXC] = rxc;
        status[STAT_TXC] = txc;
        status[STAT_DRE] = dre;

        unique case (reg_addr_e'(addr))
            A_DATA:  rdata = rx_data;
            A_STAT:  rdata = status;
            A_CTRL:  rdata = {ctrl_q, {CTRL_LSB{1'b0}}};
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign tx_en   = ctrl_q.tx_en;
    assign rx_en   = ctrl_q.rx_en;
    assign irq_rxc = gie && ctrl_q.rxc_ie && rxc;
    assign irq_txc = gie && ctrl_q.txc_ie && txc;
    assign irq_dre = gie && ctrl_q.dre_ie && dre;

endmodule

// File: rtl/bspi_master.sv
module bspi_master
    import bspi_pkg::*;
#(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       gie,
    input  logic       txc_ack,
    output logic       sck,
    output logic       mosi,
    input  logic       miso,
    output logic       irq_rxc,
    output logic       irq_txc,
    output logic       irq_dre
);

    logic  tx_en, rx_en, data_wr, rx_pop, rx_flush, txc_w1c;
    logic  rxc_flag, txc_flag, dre_flag;
    logic  load, busy, rx_push, frame_done;
    byte_t load_data, rx_data, rx_byte;

    bspi_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wdata    (wdata),
        .gie      (gie),
        .rxc      (rxc_flag),
        .txc      (txc_flag),
        .dre      (dre_flag),
        .rx_data  (rx_data),
        .rdata    (rdata),
        .tx_en    (tx_en),
        .rx_en    (rx_en),
        .data_wr  (data_wr),
        .rx_pop   (rx_pop),
        .rx_flush (rx_flush),
        .txc_w1c  (txc_w1c),
        .irq_rxc  (irq_rxc),
        .irq_txc  (irq_txc),
        .irq_dre  (irq_dre)
    );

    bspi_bufs u_bufs (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .rx_en      (rx_en),
        .data_wr    (data_wr),
        .wdata      (wdata),
        .rx_pop     (rx_pop),
        .rx_flush   (rx_flush),
        .txc_w1c    (txc_w1c),
        .txc_ack    (txc_ack),
        .busy       (busy),
        .frame_done (frame_done),
        .rx_push    (rx_push),
        .rx_byte    (rx_byte),
        .load       (load),
        .load_data  (load_data),
        .rx_data    (rx_data),
        .rxc        (rxc_flag),
        .txc        (txc_flag),
        .dre        (dre_flag)
    );

    bspi_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_data  (load_data),
        .miso       (miso),
        .sck        (sck),
        .mosi       (mosi),
        .busy       (busy),
        .rx_push    (rx_push),
        .frame_done (frame_done),
        .rx_byte    (rx_byte)
    );

endmodule

// File: rtl/bspi_master_chk.sv
module bspi_master_chk (
    input logic clk,
    input logic rst_n,
    input logic sck,
    input logic mosi,
    input logic busy,
    input logic rx_push,
    input logic frame_done,
    input logic rx_pop,
    input logic rx_flush,
    input logic txc_ack,
    input logic gie,
    input logic rxc,
    input logic txc,
    input logic dre,
    input logic irq_rxc,
    input logic irq_txc,
    input logic irq_dre
);

    p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $stable(mosi));

    p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    p_pop_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !rx_push) |=> !rxc);

    p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> !rxc);

    p_txc_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && dre) |=> txc);

    p_txc_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (txc_ack && !frame_done) |=> !txc);

    p_irq_rxc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rxc |-> (rxc && gie));

    p_irq_txc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_txc |-> (txc && gie));

    p_irq_dre_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_dre |-> (dre && gie));

endmodule

bind bspi_master bspi_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck        (sck),
    .mosi       (mosi),
    .busy       (busy),
    .rx_push    (rx_push),
    .frame_done (frame_done),
    .rx_pop     (rx_pop),
    .rx_flush   (rx_flush),
    .txc_ack    (txc_ack),
    .gie        (gie),
    .rxc        (rxc_flag),
    .txc        (txc_flag),
    .dre        (dre_flag),
    .irq_rxc    (irq_rxc),
    .irq_txc    (irq_txc),
    .irq_dre    (irq_dre)
);

// File: tb/sim_bspi_master.sv
`timescale 1ns/1ps
module sim_bspi_master;

    localparam int HD = 2;
    localparam int FRAME_WAIT = 16 * HD + 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       gie = 1'b0, txc_ack = 1'b0;
    logic       sck, mosi, miso;
    logic       irq_rxc, irq_txc, irq_dre;

    always #2.5 clk = ~clk;

    bspi_master #(.HALF_DIV(HD)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .gie(gie), .txc_ack(txc_ack),
        .sck(sck), .mosi(mosi), .miso(miso),
        .irq_rxc(irq_rxc), .irq_txc(irq_txc), .irq_dre(irq_dre)
    );

    int checks = 0, errors = 0, frames = 0, cyc = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q[$];
    logic [7:0] sl_q[$];

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- slave model and mosi monitor ----------------
    logic       sck_p = 1'b0;
    int         last_edge = 0, rises = 0;
    logic [7:0] cap = 8'd0;
    logic [7:0] sl_cur = 8'd0;
    logic [2:0] sl_bit = 3'd0;
    bit         sl_loaded = 1'b0;

    assign miso = sl_cur[3'd7 - sl_bit];

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!sl_loaded && sl_q.size() > 0) begin
                sl_cur = sl_q.pop_front();
                sl_loaded = 1'b1;
                sl_bit = 3'd0;
            end
            if (sck && !sck_p) begin
                if (rises % 8 != 0) chk("R3 half period", 8'(cyc - last_edge), 8'(HD));
                last_edge = cyc;
                cap = {cap[6:0], mosi};
                rises++;
                if (rises % 8 == 0) begin
                    frames++;
                    if (exp_q.size() == 0) begin
                        checks++; errors++;
                        $display("FAIL R11 unexpected frame actual=%h expected=none", cap);
                    end else begin
                        chk("R3 mosi byte msb first", cap, exp_q.pop_front());
                    end
                end
            end
            if (!sck && sck_p) begin
                chk("R3 half period", 8'(cyc - last_edge), 8'(HD));
                last_edge = cyc;
                if (sl_bit == 3'd7) begin
                    sl_bit = 3'd0;
                    if (sl_q.size() > 0) sl_cur = sl_q.pop_front();
                    else sl_loaded = 1'b0;
                end else begin
                    sl_bit = sl_bit + 3'd1;
                end
            end
            sck_p = sck;
        end
    end

    // ---------------- driver tasks ----------------
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(input logic [7:0] tx, input logic [7:0] sl);
        exp_q.push_back(tx);
        sl_q.push_back(sl);
        wr(2'd0, tx);
    endtask

    task automatic pchk(input string req, input logic [1:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic popchk(input string req, input logic [7:0] exp);
        @(negedge clk);
        addr = 2'd0; rd_en = 1'b1;
        #1;
        chk(req, rdata, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic irqchk(input string req, input logic [2:0] exp);
        @(negedge clk);
        #1;
        chk(req, {5'd0, irq_rxc, irq_txc, irq_dre}, {5'd0, exp});
    endtask

    task automatic ack_pulse();
        @(negedge clk); txc_ack = 1'b1;
        @(negedge clk); txc_ack = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int f0;
        idle(4);
        rst_n = 1'b1;

        // R1 reset state
        pchk("R1 status after reset", 2'd1, 8'h20);
        pchk("R1 control after reset", 2'd2, 8'h00);
        chk("R1 sck low", {7'd0, sck}, 8'h00);
        irqchk("R1 irqs low", 3'b000);

        // R9 control layout
        wr(2'd2, 8'hFF);
        pchk("R9 low bits read zero", 2'd2, 8'hF8);
        wr(2'd2, 8'h18);
        pchk("R9 enables readback", 2'd2, 8'h18);

        // R2 buffer handoff timing, R3/R4 first frame
        send(8'hA5, 8'h3C);
        addr = 2'd1; #1;
        chk("R2 buffer busy one cycle", rdata, 8'h00);
        pchk("R2 buffer free after load", 2'd1, 8'h20);
        idle(FRAME_WAIT);
        pchk("R4 R6 flags after frame", 2'd1, 8'hE0);

        // R8 read-only bits, R7 write-one-to-clear
        wr(2'd1, 8'hBF);
        pchk("R8 writes leave bits 7 and 5", 2'd1, 8'hE0);
        wr(2'd1, 8'h00);
        pchk("R7 zero write keeps txc", 2'd1, 8'hE0);
        wr(2'd1, 8'h40);
        pchk("R7 one write clears txc", 2'd1, 8'hA0);
        popchk("R4 received byte", 8'h3C);
        pchk("R4 pop clears rxc", 2'd1, 8'h20);

        // R7 acknowledge input
        send(8'h5A, 8'hC3);
        idle(FRAME_WAIT);
        ack_pulse();
        pchk("R7 ack clears txc", 2'd1, 8'hA0);
        popchk("R4 second byte", 8'hC3);

        // R6 back to back, R11 full buffer drop, R12 overwrite
        f0 = frames;
        send(8'h11, 8'h22);
        @(negedge clk);
        send(8'h33, 8'h44);
        wr(2'd0, 8'h77);
        pchk("R11 buffer stays full", 2'd1, 8'h00);
        for (int i = 0; i < 200 && frames < f0 + 1; i++) @(negedge clk);
        idle(HD + 1);
        pchk("R6 no txc between chained frames", 2'd1, 8'hA0);
        idle(FRAME_WAIT);
        pchk("R6 txc after last frame", 2'd1, 8'hE0);
        popchk("R12 newer byte kept", 8'h44);
        idle(40);
        chk("R11 dropped write sends nothing", 8'(frames), 8'(f0 + 2));
        wr(2'd1, 8'h40);

        // R5 flush and receiver disabled
        send(8'h81, 8'h18);
        idle(FRAME_WAIT);
        wr(2'd2, 8'h08);
        pchk("R5 flush clears rxc", 2'd1, 8'h60);
        wr(2'd1, 8'h40);
        send(8'h42, 8'h24);
        idle(FRAME_WAIT);
        pchk("R5 no rxc while disabled", 2'd1, 8'h60);
        wr(2'd2, 8'h18);
        pchk("R5 rxc stays clear on re-enable", 2'd1, 8'h60);
        wr(2'd1, 8'h40);

        // R11 transmitter disabled
        f0 = frames;
        wr(2'd2, 8'h10);
        wr(2'd0, 8'h99);
        pchk("R11 buffer free with tx off", 2'd1, 8'h20);
        idle(40);
        chk("R11 no frame with tx off", 8'(frames), 8'(f0));
        chk("R11 sck idle", {7'd0, sck}, 8'h00);

        // R10 interrupt gating
        wr(2'd2, 8'hF8);
        irqchk("R10 gie low masks all", 3'b000);
        gie = 1'b1;
        irqchk("R10 dre request", 3'b001);
        send(8'h0F, 8'hF0);
        idle(FRAME_WAIT);
        irqchk("R10 rxc and txc requests", 3'b111);
        ack_pulse();
        irqchk("R10 txc request drops on ack", 3'b101);
        wr(2'd2, 8'h78);
        irqchk("R10 rxc enable masks", 3'b001);
        gie = 1'b0;
        irqchk("R10 gie off", 3'b000);
        popchk("R4 last byte", 8'hF0);

        idle(5);
        chk("R3 all expected frames seen", 8'(exp_q.size()), 8'd0);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule